// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Two-Character Holding Buffer

This block receives asynchronous serial characters on a single line: a low start bit, eight data bits sent least significant bit first, an optional parity bit, and one or two stop bits. A free-running divider makes a tick at sixteen times the bit rate. The receiver finds a falling edge on the line, confirms the start bit at its middle, and then samples each later bit at its centre. Every completed character goes into a two-entry first-in first-out holding buffer.

While both entries are occupied, the shift register can still take in one more character. If an entry is freed before that character's first stop bit is sampled, the character is stored. If no entry has been freed by then, the character is dropped and the overrun flag is set.

The parity, framing and overrun flags are sticky. Each one is cleared by pulsing its own bit of a clear input. Reception carries on after any error. The buffer read port always shows the oldest character, and a one-cycle read pulse removes that character.

Top module: `uart_rx_dual`

## Requirements
- R1: After reset, `one_rdy_o`, `two_rdy_o`, `par_err_o`, `frm_err_o` and `ovr_err_o` are all 0.
- R2: The receiver takes a frame made of a low start bit, 8 data bits sent least significant bit first, then the stop bits. The data byte appears on `rd_data_o` once the frame completes.
- R3: A low pulse on the line that has gone high again by the middle of the start bit (8 oversampling ticks after the falling edge) is rejected. No character is stored.
- R4: `par_mode_i` selects the parity mode: 00 = none, 01 = even, 10 = odd, 11 = none. With parity on, one parity bit follows the data bits. If that bit does not match the data, `par_err_o` is set and the character is still stored.
- R5: If the first stop bit is sampled as 0, `frm_err_o` is set and the character is still stored. When `two_stop_i` = 1, the second stop bit is not checked.
- R6: `one_rdy_o` is 1 when at least one character is buffered. `two_rdy_o` is 1 when both entries are occupied.
- R7: `rd_data_o` shows the oldest buffered character. A one-cycle `rd_i` pulse removes that character, so the next character becomes visible after that clock edge.
- R8: A third character can be received while both entries are occupied. If a read frees an entry before that character completes, it is stored and no overrun is flagged.
- R9: If a character completes while both entries are still occupied, it is discarded, `ovr_err_o` is set, and the buffered characters are unchanged.
- R10: If a character completes in the same clock cycle as a read of a full buffer, the character is stored and no overrun is flagged.
- R11: `err_clr_i` bit 0 clears the parity flag, bit 1 clears the framing flag, and bit 2 clears the overrun flag. Each flag stays set until its own bit is pulsed, and clearing one flag leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line, idles high |
| baud_div_i | input | DIV_W | Clock cycles per oversampling tick (0 is treated as 1) |
| par_mode_i | input | 2 | Parity mode: 00 none, 01 even, 10 odd, 11 none |
| two_stop_i | input | 1 | 1 = two stop bits per frame |
| rd_i | input | 1 | Read pulse: removes the oldest character |
| err_clr_i | input | 3 | Write-1 clear: bit 0 parity, bit 1 framing, bit 2 overrun |
| rd_data_o | output | DATA_W | Oldest buffered character |
| one_rdy_o | output | 1 | At least one character buffered |
| two_rdy_o | output | 1 | Both entries occupied |
| par_err_o | output | 1 | Sticky parity error flag |
| frm_err_o | output | 1 | Sticky framing error flag |
| ovr_err_o | output | 1 | Sticky overrun error flag |

## Verification
The hardest case to reach from the ports is R10: a read of a full buffer that lands in the same clock cycle as the completion of a character. The completion event is internal and is never brought out.

The bench reaches it by calibration. With the divider set to 1, the tick fires on every cycle, so frame timing is fully deterministic. The bench first sends a character into a full buffer without reading and records how many cycles pass between driving the start bit and the rise of the overrun flag. It then clears the flag, refills the buffer, and sends another character in exactly the same way, holding `rd_i` high for the one cycle just before that recorded offset.

// File: rtl/rx_pkg.sv
package rx_pkg;

  // oversampling ratio of the bit clock
  localparam int OVS = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_STOP2
  } rx_state_e;

  // parity mode encodings on par_mode_i
  localparam logic [1:0] PM_EVEN = 2'b01;
  localparam logic [1:0] PM_ODD  = 2'b10;

  function automatic logic par_enabled(input logic [1:0] mode);
    return (mode == PM_EVEN) || (mode == PM_ODD);
  endfunction

endpackage

// File: rtl/rx_tick_gen.sv
module rx_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] limit;

  // a divisor of 0 behaves like 1: tick every cycle
  assign limit  = (div_i == '0) ? '0 : div_i - DIV_W'(1);
  assign tick_o = (cnt_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + DIV_W'(1);
  end

endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic [1:0]        par_mode_i,
  input  logic              two_stop_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              par_bad_o,
  output logic              frm_bad_o
);

  localparam int CW   = $clog2(OVS);
  localparam int BW   = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int HALF = OVS / 2;

  rx_state_e         state_q;
  logic [CW-1:0]     cnt_q;
  logic [BW-1:0]     bit_q;
  logic [DATA_W-1:0] shift_q;
  logic              par_q;
  logic              rx_prev_q;

  // named internal events
  logic fall_ev, mid_ev, half_ev, last_bit;
  assign fall_ev  = rx_prev_q & ~rx_i;
  assign mid_ev   = tick_i && (cnt_q == CW'(OVS - 1));
  assign half_ev  = tick_i && (cnt_q == CW'(HALF - 1));
  assign last_bit = (bit_q == BW'(DATA_W - 1));

  // expected parity bit: even mode makes the total count of ones even
  function automatic logic exp_parity(input logic [DATA_W-1:0] d,
                                      input logic [1:0] mode);
    return (mode == PM_ODD) ? ~(^d) : (^d);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      bit_q     <= '0;
      shift_q   <= '0;
      par_q     <= 1'b0;
      rx_prev_q <= 1'b1;
      done_o    <= 1'b0;
      data_o    <= '0;
      par_bad_o <= 1'b0;
      frm_bad_o <= 1'b0;
    end else begin
      rx_prev_q <= rx_i;
      done_o    <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (fall_ev) begin
            state_q <= ST_START;
            cnt_q   <= '0;
          end
        end
        ST_START: begin
          if (half_ev) begin
            cnt_q   <= '0;
            bit_q   <= '0;
            state_q <= rx_i ? ST_IDLE : ST_DATA;
          end else if (tick_i) begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        ST_DATA: begin
          if (mid_ev) begin
            shift_q <= {rx_i, shift_q[DATA_W-1:1]};
            cnt_q   <= '0;
            if (last_bit) state_q <= par_enabled(par_mode_i) ? ST_PAR : ST_STOP;
            else          bit_q   <= bit_q + BW'(1);
          end else if (tick_i) begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        ST_PAR: begin
          if (mid_ev) begin
            par_q   <= rx_i;
            cnt_q   <= '0;
            state_q <= ST_STOP;
          end else if (tick_i) begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        ST_STOP: begin
          if (mid_ev) begin
            done_o    <= 1'b1;
            data_o    <= shift_q;
            frm_bad_o <= ~rx_i;
            par_bad_o <= par_enabled(par_mode_i) &&
                         (par_q != exp_parity(shift_q, par_mode_i));
            cnt_q     <= '0;
            state_q   <= two_stop_i ? ST_STOP2 : ST_IDLE;
          end else if (tick_i) begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        ST_STOP2: begin
          // second stop bit is timed but never checked
          if (mid_ev) begin
            cnt_q   <= '0;
            state_q <= ST_IDLE;
          end else if (tick_i) begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R3: a start bit seen high again at mid-bit goes back to idle with no character
  p_start_glitch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START && half_ev && rx_i) |=> (state_q == ST_IDLE && !done_o));

  // R5: completion happens only as the first stop bit is sampled
  p_done_at_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (state_q == ST_IDLE || state_q == ST_STOP2));

  // R4: parity is never reported bad when parity is disabled
  p_no_par_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_ev && state_q == ST_STOP && !par_enabled(par_mode_i)) |=> !par_bad_o);

endmodule

// File: rtl/rx_buf.sv
module rx_buf #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              one_o,
  output logic              full_o,
  output logic              ovr_o
);

  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PW-1:0]     wr_q, rd_q;
  logic [CNT_W-1:0]  count_q;

  // named internal events
  logic pop, push;
  assign full_o = (count_q == CNT_W'(DEPTH));
  assign one_o  = (count_q != '0);
  assign pop    = rd_i && one_o;
  assign push   = push_req_i && (!full_o || pop);
  assign ovr_o  = push_req_i && full_o && !pop;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign rd_data_o = mem_q[rd_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= '0;
      rd_q    <= '0;
      count_q <= '0;
    end else begin
      if (push) wr_q <= ptr_next(wr_q);
      if (pop)  rd_q <= ptr_next(rd_q);
      if (push && !pop)      count_q <= count_q + CNT_W'(1);
      else if (pop && !push) count_q <= count_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wr_q] <= data_i;
  end

  // R9: occupancy never exceeds the depth
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH));

  // R9: a dropped character leaves the buffer full and untouched
  p_ovr_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_o |=> (full_o && $stable(rd_q)));

  // R10: a push and a pop together on a full buffer keep it full
  p_simul_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req_i && rd_i && full_o) |=> full_o);

  // R7: a lone pop lowers occupancy by one
  p_pop_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push_req_i) |=> (count_q == $past(count_q) - CNT_W'(1)));

  // R6: full implies non-empty
  p_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> one_o);

endmodule

// File: rtl/uart_rx_dual.sv
module uart_rx_dual #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_i,
  input  logic [DIV_W-1:0]  baud_div_i,
  input  logic [1:0]        par_mode_i,
  input  logic              two_stop_i,
  input  logic              rd_i,
  input  logic [2:0]        err_clr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              one_rdy_o,
  output logic              two_rdy_o,
  output logic              par_err_o,
  output logic              frm_err_o,
  output logic              ovr_err_o
);

  logic [1:0]        sync_q;
  logic              rx_s, tick;
  logic              done_ev, par_bad, frm_bad, ovr_ev;
  logic [DATA_W-1:0] char_data;

  // two-stage synchronizer, idles high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rx_i};
  end
  assign rx_s = sync_q[1];

  rx_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .div_i  (baud_div_i),
    .tick_o (tick)
  );

  rx_frame #(.DATA_W(DATA_W)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick),
    .rx_i       (rx_s),
    .par_mode_i (par_mode_i),
    .two_stop_i (two_stop_i),
    .done_o     (done_ev),
    .data_o     (char_data),
    .par_bad_o  (par_bad),
    .frm_bad_o  (frm_bad)
  );

  rx_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_req_i (done_ev),
    .data_i     (char_data),
    .rd_i       (rd_i),
    .rd_data_o  (rd_data_o),
    .one_o      (one_rdy_o),
    .full_o     (two_rdy_o),
    .ovr_o      (ovr_ev)
  );

  // sticky flags: a new error wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_err_o <= 1'b0;
      frm_err_o <= 1'b0;
      ovr_err_o <= 1'b0;
    end else begin
      par_err_o <= (par_err_o & ~err_clr_i[0]) | (done_ev & par_bad);
      frm_err_o <= (frm_err_o & ~err_clr_i[1]) | (done_ev & frm_bad);
      ovr_err_o <= (ovr_err_o & ~err_clr_i[2]) | ovr_ev;
    end
  end

  // R11: a set flag holds while its clear bit is low
  p_sticky_par_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err_o && !err_clr_i[0]) |=> par_err_o);

  p_sticky_ovr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_err_o && !err_clr_i[2]) |=> ovr_err_o);

  // R11: clearing framing with no new framing error empties the flag
  p_clear_frm_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr_i[1] && !(done_ev && frm_bad)) |=> !frm_err_o);

  // R9: overrun rises only with a completion
  p_ovr_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_err_o) |-> $past(done_ev));

endmodule

// File: tb/tb_uart_rx_dual.sv
module tb_uart_rx_dual;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  int         div_cfg = 2;
  logic [1:0] pmode = 2'b00;
  logic       two_stop = 1'b0;
  logic       rd = 1'b0;
  logic [2:0] clr = 3'b000;
  logic [7:0] rd_data;
  logic       one_rdy, two_rdy, perr, ferr, oerr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_rx_dual dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_i       (rx),
    .baud_div_i (div_cfg[7:0]),
    .par_mode_i (pmode),
    .two_stop_i (two_stop),
    .rd_i       (rd),
    .err_clr_i  (clr),
    .rd_data_o  (rd_data),
    .one_rdy_o  (one_rdy),
    .two_rdy_o  (two_rdy),
    .par_err_o  (perr),
    .frm_err_o  (ferr),
    .ovr_err_o  (oerr)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic even_bit(input logic [7:0] d);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += d[i];
    return (ones % 2) == 1;
  endfunction

  // drives a full frame from a negedge, then two idle bits
  task automatic send_frame(input logic [7:0] d, input logic has_par,
                            input logic pbit, input logic s1, input logic s2);
    int bp = 16 * div_cfg;
    rx = 1'b0; repeat (bp) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = d[i]; repeat (bp) @(negedge clk);
    end
    if (has_par) begin rx = pbit; repeat (bp) @(negedge clk); end
    rx = s1; repeat (bp) @(negedge clk);
    if (two_stop) begin rx = s2; repeat (bp) @(negedge clk); end
    rx = 1'b1; repeat (2 * bp) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d);
    send_frame(d, 1'b0, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic pop_expect(input string req, input logic [7:0] exp);
    check(req, one_rdy, 1);
    check(req, rd_data, exp);
    rd = 1'b1; @(negedge clk);
    rd = 1'b0; @(negedge clk);
  endtask

  task automatic clear(input logic [2:0] m);
    clr = m; @(negedge clk);
    clr = 3'b000; @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 one_rdy", one_rdy, 0);
    check("R1 two_rdy", two_rdy, 0);
    check("R1 flags", {perr, ferr, oerr}, 0);
  endtask

  task automatic t_basic;
    send(8'hA5);
    check("R6 one after one char", one_rdy, 1);
    check("R6 two after one char", two_rdy, 0);
    check("R2 data lsb first", rd_data, 8'hA5);
    pop_expect("R7 pop", 8'hA5);
    check("R7 empty after pop", one_rdy, 0);
    send(8'h01);
    pop_expect("R2 single low bit", 8'h01);
    check("R1 no errors on clean frames", {perr, ferr, oerr}, 0);
  endtask

  task automatic t_glitch;
    rx = 1'b0; repeat (3) @(negedge clk);
    rx = 1'b1; repeat (96) @(negedge clk);
    check("R3 glitch no char", one_rdy, 0);
    check("R3 glitch no flags", {perr, ferr, oerr}, 0);
  endtask

  task automatic t_parity;
    pmode = 2'b01;
    send_frame(8'h3C, 1'b1, even_bit(8'h3C), 1'b1, 1'b1);
    check("R4 even good no flag", perr, 0);
    pop_expect("R4 even good data", 8'h3C);
    send_frame(8'h3D, 1'b1, ~even_bit(8'h3D), 1'b1, 1'b1);
    check("R4 even bad flag", perr, 1);
    pop_expect("R4 even bad still stored", 8'h3D);
    clear(3'b001);
    check("R11 parity cleared", perr, 0);
    pmode = 2'b10;
    send_frame(8'h7E, 1'b1, ~even_bit(8'h7E), 1'b1, 1'b1);
    check("R4 odd good no flag", perr, 0);
    pop_expect("R4 odd good data", 8'h7E);
    send_frame(8'h80, 1'b1, even_bit(8'h80), 1'b1, 1'b1);
    check("R4 odd bad flag", perr, 1);
    pop_expect("R4 odd bad stored", 8'h80);
    clear(3'b001);
    pmode = 2'b00;
  endtask

  task automatic t_frame;
    send_frame(8'h55, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R5 framing flag", ferr, 1);
    pop_expect("R5 framing char stored", 8'h55);
    clear(3'b010);
    check("R11 framing cleared", ferr, 0);
    two_stop = 1'b1;
    send_frame(8'hC3, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R5 second stop unchecked", ferr, 0);
    pop_expect("R5 two stop data", 8'hC3);
    send_frame(8'h3A, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R5 first of two stops checked", ferr, 1);
    pop_expect("R5 two stop bad data", 8'h3A);
    clear(3'b010);
    two_stop = 1'b0;
  endtask

  task automatic t_overrun;
    send(8'h11);
    send(8'h22);
    check("R6 two entries", two_rdy, 1);
    send(8'h33);
    check("R9 overrun flag", oerr, 1);
    pop_expect("R9 oldest kept", 8'h11);
    check("R6 two cleared after pop", two_rdy, 0);
    pop_expect("R9 second kept", 8'h22);
    check("R9 third discarded", one_rdy, 0);
    clear(3'b100);
    check("R11 overrun cleared", oerr, 0);
  endtask

  task automatic t_third_held;
    send(8'h44);
    send(8'h55);
    fork
      send(8'h66);
      begin
        repeat (5 * 16 * div_cfg) @(negedge clk);
        pop_expect("R8 pop during third", 8'h44);
      end
    join
    check("R8 no overrun", oerr, 0);
    check("R8 full again", two_rdy, 1);
    pop_expect("R8 second", 8'h55);
    pop_expect("R8 third stored", 8'h66);
  endtask

  task automatic t_simul;
    int t0, hit;
    div_cfg = 1;
    repeat (40) @(negedge clk);
    send(8'hA1);
    send(8'hA2);
    hit = -1;
    t0 = cyc;
    fork
      send(8'hA3);
      for (int k = 0; k < 400; k++) begin
        @(negedge clk);
        if (oerr && hit < 0) hit = cyc - t0;
      end
    join
    check("R9 calibration overrun", oerr, 1);
    clear(3'b100);
    pop_expect("R9 cal first", 8'hA1);
    pop_expect("R9 cal second", 8'hA2);
    send(8'hB1);
    send(8'hB2);
    t0 = cyc;
    fork
      send(8'hB3);
      begin
        while (cyc - t0 < hit - 1) @(negedge clk);
        check("R7 oldest at simul pop", rd_data, 8'hB1);
        rd = 1'b1; @(negedge clk);
        rd = 1'b0;
      end
    join
    check("R10 no overrun on simul", oerr, 0);
    check("R10 still full", two_rdy, 1);
    pop_expect("R10 second", 8'hB2);
    pop_expect("R10 new char stored", 8'hB3);
    check("R10 empty", one_rdy, 0);
    div_cfg = 2;
  endtask

  task automatic t_clear_indep;
    pmode = 2'b01;
    send(8'h0F);
    send(8'hF0);
    send_frame(8'h5A, 1'b1, ~even_bit(8'h5A), 1'b1, 1'b1);
    check("R11 both set", {perr, oerr}, 2'b11);
    clear(3'b100);
    check("R11 overrun cleared alone", oerr, 0);
    check("R11 parity kept", perr, 1);
    repeat (20) @(negedge clk);
    check("R11 parity still sticky", perr, 1);
    clear(3'b001);
    pop_expect("R11 drain a", 8'h0F);
    pop_expect("R11 drain b", 8'hF0);
    pmode = 2'b00;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_basic;
    t_glitch;
    t_parity;
    t_frame;
    t_overrun;
    t_third_held;
    t_simul;
    t_clear_indep;
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule